// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Interface

This block is the digital front end of a two-channel digital-to-analog converter. A host writes 16-bit command words over a three-wire serial port: an active-low frame select, a serial clock and a data input. Each word is collected in a shift register. At the end of the frame the word is decoded and its data is written into one of two per-channel input registers. A second stage of registers, the DAC registers, holds the codes that the converter uses. These codes are presented as two parallel output buses. Data always reaches a DAC register by way of its input register or the shift register, never straight from the pins.

A serial data output supports two uses. In chained mode it carries the top bit of the shift register, so several devices can share one frame, each one's output feeding the next one's input. After a readback command, it returns the chosen DAC code during the following frame. An active-low load strobe moves both input registers into the DAC registers at once. While the strobe is held low, every input register write passes straight through to its DAC register. An asynchronous active-low clear zeroes both DAC registers and leaves the input registers as they are.

The serial pins are oversampled by the system clock. The serial clock must therefore stay low and high for at least four system clock cycles each.

Top module: `dual_dac_regif`

## Requirements
- R1: After the power-up reset, both code outputs and the serial output are zero, and the shift register, both input registers and both DAC registers hold zero.
- R2: A frame is 16 bits, sent MSB first. Each bit is sampled on a falling serial clock edge while frame select is low. The command executes when frame select rises. Bits 15..12 hold the command, and the channel code is the top WIDTH bits of bits 11..0.
- R3: Command codes are: 0 no-op, 1 write input A and DAC A, 2 write input B and DAC B, 3 write input A only, 4 write input B only, 5 copy both input registers into both DAC registers, 6 read back DAC A, 7 read back DAC B, 8 chained mode on, 9 chained mode off.
- R4: Commands 3 and 4 leave both DAC registers unchanged while the load strobe is high.
- R5: Commands 1 and 2 update the addressed input register and DAC register together and leave the other channel unchanged.
- R6: Command 5 copies input A into DAC A and input B into DAC B in the same cycle.
- R7: With chained mode off, a frame of any length other than 16 clocks is discarded.
- R8: A low load strobe copies both input registers into the DAC registers. While the strobe is held low, a later input register write reaches its DAC register without any other command.
- R9: A low clear input zeroes both DAC registers asynchronously and leaves both input registers unchanged. Command 5 afterwards restores the earlier input values.
- R10: After command 6 or 7, the next frame shifts out the chosen DAC code, MSB first, on the serial output. The word shifted out has zeros in bits 15..12 and the code left-justified in bits 11..0. The serial output changes after rising serial clock edges. The frame after that returns to a low output.
- R11: With chained mode on, the serial output presents bit 15 of the shift register during each frame. A frame of 16 clocks or more executes the last 16 bits received, and a shorter frame is discarded.
- R12: The serial output is low while frame select is high. It is also low during a frame when neither chained mode nor a pending readback enables it.
- R13: Command codes 10 to 15 have no effect on either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Power-up reset, asynchronous, active low |
| frameSelN | input | 1 | Serial frame select, active low |
| serClk | input | 1 | Serial clock; data is sampled on its falling edge |
| serIn | input | 1 | Serial data input |
| loadN | input | 1 | Load strobe, active low |
| clearN | input | 1 | Asynchronous clear of the DAC registers, active low |
| serOut | output | 1 | Serial data output for chaining and readback |
| codeA | output | WIDTH | Channel A DAC register |
| codeB | output | WIDTH | Channel B DAC register |

## Verification
The hardest state to reach is the chained 32-clock frame. It must execute only its last 16 bits while the serial output carries the previous frame's word followed by the first half of the new one. The stimulus first sends a chain-enable word and then one long frame. The bench predicts both halves of the output stream and the channel that the second half writes. Readback is reached the same way, through a read command followed by a no-op frame. The bench captures the returned code bit by bit and then checks that a third frame leaves the output low.

// File: rtl/dual_dac_regif_pkg.sv
package dual_dac_regif_pkg;

  // Frame layout: command nibble above a 12-bit data field.
  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 4;
  localparam int FIELD_BITS = FRAME_BITS - CMD_BITS;

  typedef enum logic [CMD_BITS-1:0] {
    CMD_NOP       = 4'd0,
    CMD_WRUPD_A   = 4'd1,
    CMD_WRUPD_B   = 4'd2,
    CMD_WR_A      = 4'd3,
    CMD_WR_B      = 4'd4,
    CMD_UPD_ALL   = 4'd5,
    CMD_RD_A      = 4'd6,
    CMD_RD_B      = 4'd7,
    CMD_CHAIN_ON  = 4'd8,
    CMD_CHAIN_OFF = 4'd9
  } cmd_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic shiftEn;    // sample one serial bit
    logic outTick;    // serial clock rose inside a frame
    logic outEn;      // serial output carries shift register bit 15
    logic frameIdle;  // frame select is high
    logic wrA;
    logic wrB;
    logic updA;
    logic updB;
    logic rdA;
    logic rdB;
    logic passThru;   // load strobe held low
  } strobe_t;

endpackage

// File: rtl/dual_dac_sync.sv
module dual_dac_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) chain[s] <= chain[s-1];
      chain[0] <= din;
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dual_dac_regif_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameQ,
  input  logic                sclkQ,
  input  logic                loadQ,
  input  logic [CMD_BITS-1:0] cmdField,
  output strobe_t             st
);

  localparam int              CNT_W    = $clog2(FRAME_BITS) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic             framePrev;
  logic             sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             chainOn;
  logic             rdPend;

  logic inFrame, frameFall, frameRise, sclkFall, sclkRise;
  logic frameOk, execute;
  cmd_e cmd;

  assign inFrame   = ~frameQ;
  assign frameFall = framePrev & ~frameQ;
  assign frameRise = ~framePrev & frameQ;
  assign sclkFall  = sclkPrev & ~sclkQ & inFrame;
  assign sclkRise  = ~sclkPrev & sclkQ & inFrame;
  assign cmd       = cmd_e'(cmdField);

  assign frameOk = (bitCnt == CNT_FULL) || (chainOn && (bitCnt > CNT_FULL));
  assign execute = frameRise & frameOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      framePrev <= 1'b1;
      sclkPrev  <= 1'b0;
    end else begin
      framePrev <= frameQ;
      sclkPrev  <= sclkQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (frameFall) begin
      bitCnt <= '0;
    end else if (sclkFall && (bitCnt != CNT_MAX)) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainOn <= 1'b0;
      rdPend  <= 1'b0;
    end else if (frameRise) begin
      rdPend <= execute && ((cmd == CMD_RD_A) || (cmd == CMD_RD_B));
      if (execute && (cmd == CMD_CHAIN_ON))  chainOn <= 1'b1;
      if (execute && (cmd == CMD_CHAIN_OFF)) chainOn <= 1'b0;
    end
  end

  always_comb begin
    st           = '0;
    st.shiftEn   = sclkFall;
    st.outTick   = sclkRise;
    st.outEn     = chainOn | rdPend;
    st.frameIdle = frameQ;
    st.passThru  = ~loadQ;
    if (execute) begin
      case (cmd)
        CMD_WRUPD_A: begin st.wrA = 1'b1; st.updA = 1'b1; end
        CMD_WRUPD_B: begin st.wrB = 1'b1; st.updB = 1'b1; end
        CMD_WR_A:    st.wrA = 1'b1;
        CMD_WR_B:    st.wrB = 1'b1;
        CMD_UPD_ALL: begin st.updA = 1'b1; st.updB = 1'b1; end
        CMD_RD_A:    st.rdA = 1'b1;
        CMD_RD_B:    st.rdB = 1'b1;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/dual_dac_datapath.sv
module dual_dac_datapath
  import dual_dac_regif_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearN,
  input  logic                serInQ,
  input  strobe_t             st,
  output logic [CMD_BITS-1:0] cmdField,
  output logic                serOut,
  output logic [WIDTH-1:0]    codeA,
  output logic [WIDTH-1:0]    codeB,
  output logic [WIDTH-1:0]    inRegA,
  output logic [WIDTH-1:0]    inRegB
);

  logic [FRAME_BITS-1:0]   shiftQ;
  logic [FRAME_BITS-1:0]   rbWord;
  logic [WIDTH-1:0]        newCode;
  logic [1:0]              wrV, updV;
  logic [1:0][WIDTH-1:0]   inV, dacV;

  assign newCode  = shiftQ[FIELD_BITS-1 -: WIDTH];
  assign cmdField = shiftQ[FRAME_BITS-1 -: CMD_BITS];
  assign wrV      = {st.wrB, st.wrA};
  assign updV     = {st.updB, st.updA};

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      logic [WIDTH-1:0] inQ;
      logic [WIDTH-1:0] dacQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) inQ <= '0;
        else if (wrV[ch]) inQ <= newCode;
      end

      always_ff @(posedge clk or negedge rstN or negedge clearN) begin
        if (!rstN || !clearN) begin
          dacQ <= '0;
        end else if (updV[ch]) begin
          dacQ <= wrV[ch] ? newCode : inQ;
        end else if (st.passThru) begin
          dacQ <= inQ;
        end
      end

      assign inV[ch]  = inQ;
      assign dacV[ch] = dacQ;
    end
  endgenerate

  always_comb begin
    rbWord = '0;
    rbWord[FIELD_BITS-1 -: WIDTH] = st.rdB ? dacV[1] : dacV[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (st.shiftEn) begin
      shiftQ <= {shiftQ[FRAME_BITS-2:0], serInQ};
    end else if (st.rdA || st.rdB) begin
      shiftQ <= rbWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serOut <= 1'b0;
    end else if (st.frameIdle) begin
      serOut <= 1'b0;
    end else if (st.outTick) begin
      serOut <= st.outEn ? shiftQ[FRAME_BITS-1] : 1'b0;
    end
  end

  assign codeA  = dacV[0];
  assign codeB  = dacV[1];
  assign inRegA = inV[0];
  assign inRegB = inV[1];

endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
  import dual_dac_regif_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSelN,
  input  logic             serClk,
  input  logic             serIn,
  input  logic             loadN,
  input  logic             clearN,
  output logic             serOut,
  output logic [WIDTH-1:0] codeA,
  output logic [WIDTH-1:0] codeB
);

  logic [3:0]          pinsQ;
  logic [CMD_BITS-1:0] cmdField;
  logic [WIDTH-1:0]    inRegA, inRegB;
  strobe_t             strobe;

  // Bit order: {frame select, serial clock, serial data, load strobe}.
  dual_dac_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1001)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({frameSelN, serClk, serIn, loadN}),
    .dout(pinsQ)
  );

  dual_dac_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameQ  (pinsQ[3]),
    .sclkQ   (pinsQ[2]),
    .loadQ   (pinsQ[0]),
    .cmdField(cmdField),
    .st      (strobe)
  );

  dual_dac_datapath #(
    .WIDTH(WIDTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .clearN  (clearN),
    .serInQ  (pinsQ[1]),
    .st      (strobe),
    .cmdField(cmdField),
    .serOut  (serOut),
    .codeA   (codeA),
    .codeB   (codeB),
    .inRegA  (inRegA),
    .inRegB  (inRegB)
  );

endmodule

// File: rtl/dual_dac_regif_chk.sv
module dual_dac_regif_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             clearN,
  input logic             serOut,
  input logic [WIDTH-1:0] codeA,
  input logic [WIDTH-1:0] codeB,
  input logic [WIDTH-1:0] inRegA,
  input logic             frameIdle,
  input logic             outEn,
  input logic             passThru,
  input logic             wrA,
  input logic             updA
);

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |-> (codeA == '0) && (codeB == '0));

  // R12
  idle_out_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameIdle |=> !serOut);

  // R12
  gated_out_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outEn && !frameIdle) |=> !serOut);

  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!passThru && !updA && clearN) |=> (!clearN || $stable(codeA)));

  // R8
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (passThru && !updA && clearN) |=> (!clearN || codeA == $past(inRegA)));

  // R5
  wr_upd_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrA && updA && clearN) |=> (!clearN || codeA == inRegA));

endmodule

bind dual_dac_regif dual_dac_regif_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clearN   (clearN),
  .serOut   (serOut),
  .codeA    (codeA),
  .codeB    (codeB),
  .inRegA   (inRegA),
  .frameIdle(strobe.frameIdle),
  .outEn    (strobe.outEn),
  .passThru (strobe.passThru),
  .wrA      (strobe.wrA),
  .updA     (strobe.updA)
);

// File: tb/dual_dac_regif_bench.sv
module dual_dac_regif_bench;

  localparam int WIDTH = 12;
  localparam int HALF  = 6;   // system clocks per serial clock phase

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSelN = 1'b1;
  logic serClk = 1'b0;
  logic serIn = 1'b0;
  logic loadN = 1'b1;
  logic clearN = 1'b1;
  logic serOut;
  logic [WIDTH-1:0] codeA, codeB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_dac_regif u_dual_dac_regif (
    .clk      (clk),
    .rstN     (rstN),
    .frameSelN(frameSelN),
    .serClk   (serClk),
    .serIn    (serIn),
    .loadN    (loadN),
    .clearN   (clearN),
    .serOut   (serOut),
    .codeA    (codeA),
    .codeB    (codeB)
  );

  // {frame word, expected codeA, expected codeB}, load strobe high
  localparam logic [39:0] VEC [9] = '{
    40'h3ABC_000_000,  // R4 input A only
    40'h4123_000_000,  // R4 input B only
    40'h5000_ABC_123,  // R6 copy both
    40'h1FFF_FFF_123,  // R5 write and update A
    40'h2456_FFF_456,  // R5 write and update B
    40'h0777_FFF_456,  // R3 no-op
    40'hF999_FFF_456,  // R13 unassigned code
    40'h3001_FFF_456,  // R4 input A only again
    40'h5000_001_456   // R6 copy both, B input unchanged
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [31:0] word, input int nBits, output logic [31:0] seen);
    seen = '0;
    frameSelN = 1'b0;
    waitClk(HALF);
    for (int i = nBits - 1; i >= 0; i--) begin
      serIn  = word[i];
      serClk = 1'b1;
      waitClk(HALF);
      seen   = {seen[30:0], serOut};
      serClk = 1'b0;
      waitClk(HALF);
    end
    frameSelN = 1'b1;
    waitClk(8);
  endtask

  task automatic checkCodes(input string req, input logic [11:0] expA, input logic [11:0] expB);
    check(req, 32'(codeA), 32'(expA));
    check(req, 32'(codeB), 32'(expB));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seen;
    waitClk(3);
    // R1 reset state
    check("R1", {codeA, codeB, 7'd0, serOut}, 32'd0);
    rstN = 1'b1;
    waitClk(4);
    checkCodes("R1", 12'h000, 12'h000);
    check("R1", 32'(serOut), 32'd0);

    // R2 R3: table walk
    for (int i = 0; i < 9; i++) begin
      sendFrame({16'd0, VEC[i][39:24]}, 16, seen);
      checkCodes("R2", VEC[i][23:12], VEC[i][11:0]);
      check("R12", seen, 32'd0);
    end

    // R7 short and long frames discarded
    sendFrame(32'h0000_1AAA, 15, seen);
    checkCodes("R7", 12'h001, 12'h456);
    sendFrame(32'h0000_2BBB, 17, seen);
    checkCodes("R7", 12'h001, 12'h456);

    // R4 then R8
    sendFrame(32'h0000_3222, 16, seen);
    checkCodes("R4", 12'h001, 12'h456);
    loadN = 1'b0;
    waitClk(6);
    checkCodes("R8", 12'h222, 12'h456);
    sendFrame(32'h0000_4333, 16, seen);
    checkCodes("R8", 12'h222, 12'h333);
    loadN = 1'b1;
    waitClk(6);

    // R9 clear
    clearN = 1'b0;
    waitClk(2);
    checkCodes("R9", 12'h000, 12'h000);
    clearN = 1'b1;
    waitClk(4);
    checkCodes("R9", 12'h000, 12'h000);
    sendFrame(32'h0000_5000, 16, seen);
    checkCodes("R9", 12'h222, 12'h333);

    // R10 readback of B
    sendFrame(32'h0000_7000, 16, seen);
    check("R12", seen, 32'd0);
    sendFrame(32'h0000_0000, 16, seen);
    check("R10", seen, 32'h0000_0333);
    sendFrame(32'h0000_0000, 16, seen);
    check("R10", seen, 32'd0);
    check("R12", 32'(serOut), 32'd0);

    // R11 chained mode
    sendFrame(32'h0000_8000, 16, seen);
    check("R11", seen, 32'd0);
    sendFrame(32'h2ABC_1DEF, 32, seen);
    check("R11", seen, 32'h8000_2ABC);
    checkCodes("R11", 12'hDEF, 12'h333);
    sendFrame(32'h0000_2111, 15, seen);
    checkCodes("R11", 12'hDEF, 12'h333);
    sendFrame(32'h0000_9000, 16, seen);
    sendFrame(32'h0000_2444, 17, seen);
    checkCodes("R11", 12'hDEF, 12'h333);
    check("R12", 32'(serOut), 32'd0);

    // R13 upper unassigned code
    sendFrame(32'h0000_AFFF, 16, seen);
    checkCodes("R13", 12'hDEF, 12'h333);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule